// File: doc/BRIEF.md
# Prioritised UART Interrupt Identifier

This block merges the four interrupt causes of an asynchronous serial port into one request line and one identification byte that host software reads to find out what needs service. The four causes are a receive error or break, a received character waiting, an empty transmit holding register, and a change on a modem input. Each cause arrives as a one-cycle event pulse. The block latches the event into a pending flag. A four-bit enable register, written by the host, decides which pending flags take part in the request.

Among the enabled pending flags, the one with the highest priority is encoded into bits 2:1 of the identification byte. Bit 0 of that byte is an active-low pending flag. The interrupt line is high whenever bit 0 is low.

The identification byte is not held while software works: it always reflects the present flags. As a result, a more urgent cause that arrives during service replaces the code shown. When a cause is serviced, the next one in line appears. Each flag is cleared by the host action that services it:
- a read of the line status register,
- a read of the receive data register,
- a write to the transmit register,
- a read of the modem status register.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous active-low reset, every pending flag and every enable bit is 0, the identification byte reads 8'h01 and the interrupt line is low; an event pulse alone then does not raise the line.
- R2: The code in bits 2:1 of the identification byte is 2'b11 for receive error/break, 2'b10 for receive data, 2'b01 for transmit empty and 2'b00 for modem change, with priority in exactly that order, highest first.
- R3: Bit 0 of the identification byte is 0 exactly when some enabled source is pending, and the interrupt line is high in those same cycles. Bits 7:3 always read 0.
- R4: Writing the enable register (write strobe with an 8-bit data byte) stores data bit 0 as the receive-data enable, bit 1 as the transmit-empty enable, bit 2 as the receive-error enable and bit 3 as the modem-change enable. Data bits 7:4 have no effect.
- R5: A source whose enable bit is 0 still latches its event but is hidden from the identification byte and the interrupt line; setting the enable bit later makes it visible without a new event.
- R6: A line status read clears the receive-error flag; a receive data read clears the receive-data flag; a modem status read clears the modem flag. Each takes effect on the next clock edge.
- R7: The transmit-empty flag is cleared by a transmit register write, or by an identification read in a cycle where code 2'b01 is being shown; an identification read while another code is shown leaves it pending.
- R8: Once the shown source is cleared, the next highest enabled pending source is shown on the following cycle, until none remain.
- R9: A newly arriving higher-priority enabled source replaces the shown code on the cycle after its event.
- R10: An event pulse in the same cycle as the clear action for that source leaves the flag pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx_err | input | 1 | Pulse: receive error or break detected |
| ev_rx_data | input | 1 | Pulse: received character loaded |
| ev_tx_empty | input | 1 | Pulse: transmit holding register became empty |
| ev_modem | input | 1 | Pulse: a modem input changed state |
| ier_we | input | 1 | Enable register write strobe |
| ier_din | input | DW (8) | Enable register write data |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| rd_rbr | input | 1 | Receive data register read strobe |
| rd_iir | input | 1 | Identification byte read strobe |
| wr_thr | input | 1 | Transmit register write strobe |
| iir | output | DW (8) | Identification byte: bit 0 pending (active low), bits 2:1 code |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and four enable bits. With these defaults every enable combination, every code, and the full 8-bit byte including its reserved upper bits can be reached. The stimulus table stacks all four sources and then services them one by one, so every priority handover is observed. The table also covers hidden sources becoming visible when enabled, identification reads under both shown and not-shown conditions, and the case where an event and its clear arrive together. Directed steps cover the state right after reset and a reset in the middle of activity.

// File: rtl/uart_irq_pkg.sv
// Shared definitions for the interrupt identifier.
// Source indices equal the enable-register bit positions.
package uart_irq_pkg;
    localparam int NSRC    = 4;
    localparam int SRC_RXD = 0;
    localparam int SRC_TXE = 1;
    localparam int SRC_ERR = 2;
    localparam int SRC_MDM = 3;

    typedef enum logic [1:0] {
        ID_MODEM = 2'b00,
        ID_TXE   = 2'b01,
        ID_RXD   = 2'b10,
        ID_RXERR = 2'b11
    } irq_id_e;
endpackage

// File: rtl/irq_src_flag.sv
// One pending flag. A set request beats a clear request in the same
// cycle, so an event is never lost to a concurrent service action.
// Assumes a synchronous active-low reset.
module irq_src_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Hold the flag: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder over the enabled pending flags.
// Order: receive error, receive data, transmit empty, modem change.
// Assumes the input is already masked by the enable bits.
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output irq_id_e      id_o
);
    // Pick the highest-priority request.
    always_comb begin
        any_o = |req_i;
        if (req_i[SRC_ERR])      id_o = ID_RXERR;
        else if (req_i[SRC_RXD]) id_o = ID_RXD;
        else if (req_i[SRC_TXE]) id_o = ID_TXE;
        else                     id_o = ID_MODEM;
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identifier. It latches four event pulses, masks
// them with a host-written enable register and presents the winner as an
// identification byte plus an interrupt line. Both outputs follow the
// flags with no extra register stage.
// Assumes event and strobe inputs are single-cycle and synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DW  = 8,
    parameter int ENW = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_rx_err,
    input  logic          ev_rx_data,
    input  logic          ev_tx_empty,
    input  logic          ev_modem,
    input  logic          ier_we,
    input  logic [DW-1:0] ier_din,
    input  logic          rd_lsr,
    input  logic          rd_msr,
    input  logic          rd_rbr,
    input  logic          rd_iir,
    input  logic          wr_thr,
    output logic [DW-1:0] iir,
    output logic          irq
);
    localparam int PADW = DW - 3;

    logic [ENW-1:0] en_q;
    logic [ENW-1:0] set_v;
    logic [ENW-1:0] clr_v;
    logic [ENW-1:0] pend;
    logic [ENW-1:0] masked;
    logic           any;
    irq_id_e        id;

    // Enable register: only the low ENW data bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (ier_we) en_q <= ier_din[ENW-1:0];
    end

    // Route events to their flag slots.
    always_comb begin
        set_v          = '0;
        set_v[SRC_RXD] = ev_rx_data;
        set_v[SRC_TXE] = ev_tx_empty;
        set_v[SRC_ERR] = ev_rx_err;
        set_v[SRC_MDM] = ev_modem;
    end

    // Route service actions to their flag slots.
    always_comb begin
        clr_v          = '0;
        clr_v[SRC_RXD] = rd_rbr;
        clr_v[SRC_TXE] = wr_thr | (rd_iir & any & (id == ID_TXE));
        clr_v[SRC_ERR] = rd_lsr;
        clr_v[SRC_MDM] = rd_msr;
    end

    for (genvar g = 0; g < ENW; g++) begin : g_flag
        irq_src_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend[g])
        );
    end

    assign masked = pend & en_q;

    irq_prio_enc #(.N(ENW)) u_enc (
        .req_i (masked),
        .any_o (any),
        .id_o  (id)
    );

    // Assemble the identification byte and the request line.
    always_comb begin
        iir = {{PADW{1'b0}}, id, ~any};
        irq = any;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
// Property checker for uart_irq_ident, attached with bind below.
module uart_irq_ident_chk #(
    parameter int DW  = 8,
    parameter int ENW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_rx_err,
    input logic          ev_tx_empty,
    input logic          ier_we,
    input logic [DW-1:0] ier_din,
    input logic          rd_lsr,
    input logic          wr_thr,
    input logic [ENW-1:0] en,
    input logic [DW-1:0] iir,
    input logic          irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (iir == 8'h01 && !irq));
    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir[DW-1:3] == '0) && (irq != iir[0]));
    // R5
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && ier_din[ENW-1:0] == '0) |=> (iir == 8'h01 && !irq));
    // R6
    lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !ev_rx_err) |=> !(iir[0] == 1'b0 && iir[2:1] == 2'b11));
    // R7
    thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !ev_tx_empty) |=> !(iir[0] == 1'b0 && iir[2:1] == 2'b01));
    // R9
    err_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_err && en[2] && !(ier_we && !ier_din[2])) |=> (iir[2:0] == 3'b110));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DW(DW), .ENW(ENW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_rx_err   (ev_rx_err),
    .ev_tx_empty (ev_tx_empty),
    .ier_we      (ier_we),
    .ier_din     (ier_din),
    .rd_lsr      (rd_lsr),
    .wr_thr      (wr_thr),
    .en          (en_q),
    .iir         (iir),
    .irq         (irq)
);

// File: tb/sim_uart_irq_ident.sv
// Table-driven bench for uart_irq_ident, followed by directed reset steps.
module sim_uart_irq_ident;
    localparam int P     = 10;
    localparam int NVEC  = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_rx_err = 0, ev_rx_data = 0, ev_tx_empty = 0, ev_modem = 0;
    logic       ier_we = 0;
    logic [7:0] ier_din = '0;
    logic       rd_lsr = 0, rd_msr = 0, rd_rbr = 0, rd_iir = 0, wr_thr = 0;
    logic [7:0] iir;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(P/2) clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_err(ev_rx_err), .ev_rx_data(ev_rx_data),
        .ev_tx_empty(ev_tx_empty), .ev_modem(ev_modem),
        .ier_we(ier_we), .ier_din(ier_din),
        .rd_lsr(rd_lsr), .rd_msr(rd_msr), .rd_rbr(rd_rbr),
        .rd_iir(rd_iir), .wr_thr(wr_thr),
        .iir(iir), .irq(irq)
    );

    // Vector: [25:22] events {modem,tx,data,err}
    //         [21:17] actions {lsr,msr,rbr,iir,thr}
    //         [16] enable write, [15:8] enable data, [7:0] expected byte
    localparam logic [25:0] VEC [NVEC] = '{
        {4'b0000, 5'b00000, 1'b1, 8'h0F, 8'h01}, //  0 R4 all enabled, idle
        {4'b0100, 5'b00000, 1'b0, 8'h00, 8'h02}, //  1 R2 tx empty
        {4'b1000, 5'b00000, 1'b0, 8'h00, 8'h02}, //  2 R2 modem below tx
        {4'b0010, 5'b00000, 1'b0, 8'h00, 8'h04}, //  3 R9 data over tx
        {4'b0001, 5'b00000, 1'b0, 8'h00, 8'h06}, //  4 R9 error over data
        {4'b0000, 5'b10000, 1'b0, 8'h00, 8'h04}, //  5 R6 R8 lsr read
        {4'b0000, 5'b00100, 1'b0, 8'h00, 8'h02}, //  6 R6 R8 rbr read
        {4'b0000, 5'b00010, 1'b0, 8'h00, 8'h00}, //  7 R7 iir read clears tx
        {4'b0000, 5'b01000, 1'b0, 8'h00, 8'h01}, //  8 R6 msr read
        {4'b0010, 5'b00100, 1'b0, 8'h00, 8'h04}, //  9 R10 set beats clear
        {4'b0000, 5'b00100, 1'b0, 8'h00, 8'h01}, // 10 R6 rbr read
        {4'b0001, 5'b00000, 1'b1, 8'h00, 8'h01}, // 11 R5 error hidden
        {4'b0100, 5'b00000, 1'b0, 8'h00, 8'h01}, // 12 R5 tx hidden
        {4'b0000, 5'b00000, 1'b1, 8'hF2, 8'h02}, // 13 R4 R5 tx only
        {4'b0000, 5'b00010, 1'b0, 8'h00, 8'h01}, // 14 R7 iir read clears tx
        {4'b0000, 5'b00000, 1'b1, 8'h04, 8'h06}, // 15 R5 latched error shows
        {4'b1110, 5'b00000, 1'b1, 8'h0F, 8'h06}, // 16 R2 all four pending
        {4'b0000, 5'b00010, 1'b0, 8'h00, 8'h06}, // 17 R7 iir read, error shown
        {4'b0000, 5'b10000, 1'b0, 8'h00, 8'h04}, // 18 R8 next source
        {4'b0000, 5'b00100, 1'b0, 8'h00, 8'h02}, // 19 R7 tx survived
        {4'b0000, 5'b00001, 1'b0, 8'h00, 8'h00}, // 20 R7 thr write
        {4'b0000, 5'b01000, 1'b0, 8'h00, 8'h01}  // 21 R8 none left
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_run++;
        if (iir !== exp) begin
            n_fail++;
            $display("FAIL %s iir actual=%h expected=%h", req, iir, exp);
        end
        n_run++;
        if (irq !== ~exp[0]) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, ~exp[0]);
        end
    endtask

    task automatic step(input logic [25:0] v, input string req);
        @(negedge clk);
        {ev_modem, ev_tx_empty, ev_rx_data, ev_rx_err} = v[25:22];
        {rd_lsr, rd_msr, rd_rbr, rd_iir, wr_thr}       = v[21:17];
        ier_we  = v[16];
        ier_din = v[15:8];
        @(posedge clk);
        #(P/4);
        check(req, v[7:0]);
        @(negedge clk);
        {ev_modem, ev_tx_empty, ev_rx_data, ev_rx_err} = '0;
        {rd_lsr, rd_msr, rd_rbr, rd_iir, wr_thr}       = '0;
        ier_we = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(P/4);
        check("R1 reset", 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i], $sformatf("vec%0d", i));
        end
        // R1: reset in mid-activity clears flags and enables
        step({4'b0001, 5'b00000, 1'b1, 8'h0F, 8'h06}, "R9 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #(P/4);
        check("R1 mid reset", 8'h01);
        @(negedge clk);
        rst_n = 1'b1;
        step({4'b0010, 5'b00000, 1'b0, 8'h00, 8'h01}, "R1 enables cleared");
        step({4'b0000, 5'b00000, 1'b1, 8'h01, 8'h04}, "R5 data visible");
        finish_run();
    end

    initial begin
        #(P * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule